// File: doc/BRIEF.md
# Serial Conversion Result Transmitter

This block is the digital output stage of a 12-bit converter. It keeps the most recent conversion result, offered on a one-cycle strobe, and sends it one bit at a time on a serial data pin, most significant bit first. A format input sets the coding. Straight binary sends the result unchanged. Two's complement flips the top bit. The format and the result are both taken at the moment a transfer starts.

Two clocking schemes exist, chosen by a mode input. In internal-clock mode a convert command starts the transfer. This command is a falling edge of the logical OR of chip select and read/convert. The block then drives exactly one burst of 12 data-clock pulses, and each half period lasts a parameterized number of system clocks. Between bursts the data pin shows the tag level captured at the convert command. In external-clock mode a host supplies the data clock. The block passes it through a two-flop synchronizer and advances on its rising edges. Two events start a transfer: read/convert rising while chip select is low, or chip select falling while read/convert is high. Either one raises a sync marker. After the 12 result bits, the tag input follows, delayed by 12 data-clock cycles, so that several units can be chained.

Everything runs on one system clock. The asynchronous reset is released synchronously inside the block.

Top module: `serout_unit`

## Requirements
- R1: During reset and after its release, before any transfer starts, `sdata_out`, `sclk_out` and `sync_out` are all 0.
- R2: A transfer sends the value from the latest `res_valid` strobe before the start, most significant bit first.
- R3: When a transfer starts, `fmt_sb`=1 sends the stored value unchanged and `fmt_sb`=0 sends it with bit 11 inverted.
- R4: With `mode_ext`=0, a falling edge of (`cs_n` OR `rd_conv`) produces exactly 12 `sclk_out` pulses. Each pulse is high for HALF system clocks and low for HALF system clocks. `sclk_out` then stays at 0.
- R5: With `mode_ext`=0, `sdata_out` changes only while `sclk_out` is 0, and the first bit is present from the start of the burst.
- R6: With `mode_ext`=0 and no burst running, `sdata_out` holds the level `tag_in` had at the last convert command, even when `tag_in` changes later.
- R7: With `mode_ext`=0, a convert command that arrives during a burst is ignored. The burst still has exactly 12 pulses and carries the original word.
- R8: With `mode_ext`=1, `rd_conv` rising while `cs_n`=0, or `cs_n` falling while `rd_conv`=1, loads a new word and sets `sync_out` to 1 at the next clock. `sync_out` returns to 0 at the first accepted data-clock rising edge.
- R9: With `mode_ext`=1, each `sclk_in` rising edge advances `sdata_out` by one bit. The shift happens at the third system clock edge after the rise. After the 12 result bits, `sdata_out` carries the `tag_in` values sampled at the earlier data-clock rises, delayed by 12 data-clock cycles.
- R10: With `mode_ext`=1, an `sclk_in` rising edge does not advance `sdata_out` while the window is closed, that is, while `cs_n`=1 or `rd_conv`=0.
- R11: The mode input gates each start event. A convert command in external mode produces no `sclk_out` pulse, and an external start event in internal mode does not raise `sync_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 1: host-driven data clock, 0: block-driven burst |
| fmt_sb | input | 1 | 1: straight binary, 0: two's complement |
| res_valid | input | 1 | Result-ready strobe |
| res_data | input | DW | Conversion result |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | Read/convert control |
| tag_in | input | 1 | Chaining tag input |
| sclk_in | input | 1 | Host data clock (external mode) |
| sclk_out | output | 1 | Generated data clock (internal mode) |
| sdata_out | output | 1 | Serial data |
| sync_out | output | 1 | Transfer start marker (external mode) |

## Verification
The bench targets the following corner cases, and each one exposes a specific fault:
- The burst length: a counter off by one shows up as 11 or 13 pulses.
- The pulse width: a wrong terminal count shows up as unequal high times.
- Data changes on the wrong clock phase: this shows up as data moving while `sclk_out` is high.
- A repeated convert command in the middle of a burst: a design that restarts on it produces too many pulses.
- The two external start events, a data-clock rise with the window closed, and the tag that re-emerges 12 clocks later: a wrong window gate or a wrong tag tap gives a different word on the pin.
- The top bit in both formats, with zero, all-ones and one-hot-corner values: an inversion placed on the wrong bit changes the received word.

// File: rtl/serout_pkg.sv
package serout_pkg;

  typedef enum logic {
    BURST_IDLE = 1'b0,
    BURST_RUN  = 1'b1
  } burst_state_e;

  typedef struct packed {
    logic int_start;   // convert command accepted in internal mode
    logic ext_start;   // transfer start in external mode
    logic win_open;    // chip selected and read phase active
    logic clk_rise;    // synchronized host clock rising edge
  } ctl_ev_t;

endpackage

// File: rtl/serout_ctl.sv
module serout_ctl
  import serout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mode_ext,
  input  logic    cs_n,
  input  logic    rd_conv,
  input  logic    sclk_in,
  input  logic    burst_busy,
  output ctl_ev_t ev
);

  logic                 cs_q, rc_q;
  logic [SYNC_STAGES:0] sclk_pipe_q, sclk_pipe_d;
  logic                 conv_now, conv_prev;

  always_comb begin
    sclk_pipe_d = {sclk_pipe_q[SYNC_STAGES-1:0], sclk_in};
    conv_now    = cs_n | rd_conv;
    conv_prev   = cs_q | rc_q;

    ev.int_start = ~mode_ext & ~burst_busy & conv_prev & ~conv_now;
    ev.ext_start = mode_ext &
                   ((~rc_q & rd_conv & ~cs_n) | (cs_q & ~cs_n & rd_conv));
    ev.win_open  = ~cs_n & rd_conv;
    ev.clk_rise  = sclk_pipe_q[SYNC_STAGES-1] & ~sclk_pipe_q[SYNC_STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b1;
      rc_q        <= 1'b1;
      sclk_pipe_q <= '0;
    end else begin
      cs_q        <= cs_n;
      rc_q        <= rd_conv;
      sclk_pipe_q <= sclk_pipe_d;
    end
  end

endmodule

// File: rtl/serout_burst.sv
module serout_burst
  import serout_pkg::*;
#(
  parameter int DW   = 12,
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic sclk_o,
  output logic busy_o,
  output logic shift_o
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  burst_state_e     state_q, state_d;
  logic [CW-1:0]    phase_q, phase_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic             sclk_q, sclk_d;
  logic             phase_end;

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    bit_d     = bit_q;
    sclk_d    = sclk_q;
    shift_o   = 1'b0;
    phase_end = (phase_q == CW'(HALF - 1));
    if (state_q == BURST_IDLE) begin
      if (start) begin
        state_d = BURST_RUN;
        phase_d = '0;
        bit_d   = '0;
        sclk_d  = 1'b0;
      end
    end else begin
      phase_d = phase_q + CW'(1);
      if (phase_end) begin
        phase_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else begin
          sclk_d = 1'b0;
          if (bit_q == BW'(DW - 1)) begin
            state_d = BURST_IDLE;
          end else begin
            bit_d   = bit_q + BW'(1);
            shift_o = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BURST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign busy_o = (state_q == BURST_RUN);

  // R4: clock is low whenever no burst runs
  a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);
  // R4: pulse index never passes the last bit
  a_r4_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BW'(DW - 1));
  // R4: a burst ends together with the falling edge of its last pulse
  a_r4_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $fell(sclk_o));

endmodule

// File: rtl/serout_unit.sv
module serout_unit
  import serout_pkg::*;
#(
  parameter int DW   = 12,
  parameter int HALF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ext,
  input  logic          fmt_sb,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          cs_n,
  input  logic          rd_conv,
  input  logic          tag_in,
  input  logic          sclk_in,
  output logic          sclk_out,
  output logic          sdata_out,
  output logic          sync_out
);

  logic [1:0]    rst_pipe_q;
  logic          rst_i;
  ctl_ev_t       ev;
  logic          burst_busy, burst_shift, ext_shift;
  logic [DW-1:0] held_q, held_d, shreg_q, shreg_d, coded;
  logic          tag_q, tag_d, sync_q, sync_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  serout_ctl #(.SYNC_STAGES(2)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_i),
    .mode_ext   (mode_ext),
    .cs_n       (cs_n),
    .rd_conv    (rd_conv),
    .sclk_in    (sclk_in),
    .burst_busy (burst_busy),
    .ev         (ev)
  );

  serout_burst #(.DW(DW), .HALF(HALF)) u_burst (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (ev.int_start),
    .sclk_o  (sclk_out),
    .busy_o  (burst_busy),
    .shift_o (burst_shift)
  );

  always_comb begin
    coded     = held_q ^ {~fmt_sb, {(DW-1){1'b0}}};
    ext_shift = ev.clk_rise & ev.win_open & mode_ext & ~burst_busy;
    held_d    = res_valid ? res_data : held_q;

    shreg_d = shreg_q;
    if (ev.int_start || ev.ext_start)
      shreg_d = coded;
    else if (burst_shift)
      shreg_d = {shreg_q[DW-2:0], 1'b0};
    else if (ext_shift)
      shreg_d = {shreg_q[DW-2:0], tag_in};

    tag_d = ev.int_start ? tag_in : tag_q;

    sync_d = sync_q;
    if (ev.ext_start)    sync_d = 1'b1;
    else if (ext_shift)  sync_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      held_q  <= '0;
      shreg_q <= '0;
      tag_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      held_q  <= held_d;
      shreg_q <= shreg_d;
      tag_q   <= tag_d;
      sync_q  <= sync_d;
    end
  end

  assign sdata_out = (mode_ext || burst_busy) ? shreg_q[DW-1] : tag_q;
  assign sync_out  = sync_q;

  // R5: data is steady while the generated clock is high
  a_r5_stable_when_high: assert property (@(posedge clk) disable iff (!rst_i)
    (!mode_ext && burst_busy && sclk_out) |-> $stable(sdata_out));
  // R6: between bursts the data pin does not move
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (!mode_ext && $past(!mode_ext) && !burst_busy && $past(!burst_busy))
      |-> $stable(sdata_out));
  // R8: an external start raises the marker on the next clock
  a_r8_sync_after_start: assert property (@(posedge clk) disable iff (!rst_i)
    ev.ext_start |=> sync_out);
  // R10: a closed window freezes the external shift register
  a_r10_closed_window: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_ext && !ev.win_open && !ev.ext_start && !burst_busy)
      |=> (!mode_ext || $stable(sdata_out)));

endmodule

// File: tb/sim_serout_unit.sv
module sim_serout_unit;

  localparam int HALF = 4;
  localparam logic [11:0] TAGPAT = 12'hC35;
  // {fmt_sb, tag, value, expected word}
  localparam logic [25:0] VEC [6] = '{
    {1'b1, 1'b1, 12'hA5C, 12'hA5C},
    {1'b0, 1'b0, 12'hA5C, 12'h25C},
    {1'b1, 1'b0, 12'h000, 12'h000},
    {1'b0, 1'b1, 12'h000, 12'h800},
    {1'b0, 1'b1, 12'hFFF, 12'h7FF},
    {1'b1, 1'b0, 12'h801, 12'h801}
  };

  logic clk = 1'b0;
  logic rst_n, mode_ext, fmt_sb, res_valid, cs_n, rd_conv, tag_in, sclk_in;
  logic [11:0] res_data;
  logic sclk_out, sdata_out, sync_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serout_unit #(.DW(12), .HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .fmt_sb(fmt_sb),
    .res_valid(res_valid), .res_data(res_data), .cs_n(cs_n),
    .rd_conv(rd_conv), .tag_in(tag_in), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sdata_out(sdata_out), .sync_out(sync_out)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_result(input logic [11:0] v);
    @(negedge clk); res_data = v; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
  endtask

  // internal-mode burst; leaves cs_n=0, rd_conv=0
  task automatic int_burst(input logic [11:0] exp_w, input logic exp_tag, input bit retrig);
    int rises = 0; int hi = 0; int badlen = 0; int unstable = 0;
    logic prev = 1'b0; logic hold = 1'b0; logic [11:0] w = '0;
    @(negedge clk); cs_n = 1'b0; rd_conv = 1'b0;
    for (int cyc = 0; cyc < 2*HALF*12 + 8; cyc++) begin
      @(negedge clk);
      if (cyc == 1) tag_in = ~exp_tag;
      if (retrig && cyc == 10) rd_conv = 1'b1;
      if (retrig && cyc == 14) rd_conv = 1'b0;
      if (sclk_out && !prev) begin
        rises++; w = {w[10:0], sdata_out}; hold = sdata_out; hi = 1;
      end else if (sclk_out) begin
        hi++; if (sdata_out !== hold) unstable++;
      end else if (prev) begin
        if (hi != HALF) badlen++;
      end
      prev = sclk_out;
    end
    check(retrig ? "R7 pulse count" : "R4 pulse count", 12'(rises), 12'd12);
    check("R4 high width", 12'(badlen), 12'd0);
    check("R2/R3 internal word", w, exp_w);
    check("R5 data steady while high", 12'(unstable), 12'd0);
    check("R4 clock low after burst", {11'b0, sclk_out}, 12'd0);
    check("R6 idle data holds tag", {11'b0, sdata_out}, {11'b0, exp_tag});
  endtask

  task automatic ext_pulse(input logic tb);
    tag_in = tb; sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    sclk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ext_read(output logic [11:0] w, input logic [11:0] pat);
    for (int j = 0; j < 12; j++) begin
      w[11-j] = sdata_out;
      ext_pulse(pat[11-j]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] w, w2;
    int rises;
    logic prev;
    rst_n = 1'b0; mode_ext = 1'b0; fmt_sb = 1'b1; res_valid = 1'b0;
    res_data = '0; cs_n = 1'b1; rd_conv = 1'b1; tag_in = 1'b1; sclk_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {9'b0, sdata_out, sclk_out, sync_out}, 12'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 after release", {9'b0, sdata_out, sclk_out, sync_out}, 12'd0);

    // vector table: each entry in both modes
    for (int i = 0; i < 6; i++) begin
      fmt_sb = VEC[i][25];
      load_result(VEC[i][23:12]);
      mode_ext = 1'b0; tag_in = VEC[i][24];
      int_burst(VEC[i][11:0], VEC[i][24], 1'b0);
      // R11: read/convert rising with chip selected, internal mode
      rd_conv = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 no sync in internal mode", {11'b0, sync_out}, 12'd0);
      cs_n = 1'b1;
      @(negedge clk);
      mode_ext = 1'b1;
      @(negedge clk);
      cs_n = 1'b0; rd_conv = 1'b0;
      repeat (2) @(negedge clk);
      rd_conv = 1'b1;
      @(negedge clk);
      check("R8 sync on read rising", {11'b0, sync_out}, 12'd1);
      check("R2 first external bit", {11'b0, sdata_out}, {11'b0, VEC[i][11]});
      ext_read(w, TAGPAT);
      check("R9 external word", w, VEC[i][11:0]);
      check("R8 sync cleared", {11'b0, sync_out}, 12'd0);
      ext_read(w2, 12'h000);
      check("R9 tag delayed 12", w2, TAGPAT);
      cs_n = 1'b1; mode_ext = 1'b0;
      @(negedge clk);
    end

    // R2/R7: latest of two results, restart attempt during the burst
    fmt_sb = 1'b1;
    load_result(12'hFFF);
    load_result(12'h3C6);
    tag_in = 1'b1;
    @(negedge clk); cs_n = 1'b1; rd_conv = 1'b1;
    int_burst(12'h3C6, 1'b1, 1'b1);
    repeat (2*HALF + 4) @(negedge clk);
    check("R7 no restart", {11'b0, sclk_out}, 12'd0);
    cs_n = 1'b1; rd_conv = 1'b1;
    @(negedge clk);

    // R10 and the chip-select start event
    load_result(12'h5A3);
    mode_ext = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; rd_conv = 1'b0;
    repeat (2) @(negedge clk);
    rd_conv = 1'b1;
    @(negedge clk);
    ext_pulse(1'b0); ext_pulse(1'b0);
    check("R9 third bit", {11'b0, sdata_out}, 12'd0);
    rd_conv = 1'b0;
    @(negedge clk);
    ext_pulse(1'b0);
    check("R10 read low ignores clock", {11'b0, sdata_out}, 12'd0);
    cs_n = 1'b1;
    @(negedge clk);
    rd_conv = 1'b1;
    @(negedge clk);
    ext_pulse(1'b0);
    check("R10 deselected ignores clock", {11'b0, sdata_out}, 12'd0);
    cs_n = 1'b0;
    @(negedge clk);
    check("R8 sync on select falling", {11'b0, sync_out}, 12'd1);
    ext_read(w, 12'h000);
    check("R8 word after select start", w, 12'h5A3);

    // R11: convert command in external mode drives no clock
    cs_n = 1'b1; rd_conv = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; rd_conv = 1'b0;
    rises = 0; prev = 1'b0;
    for (int k = 0; k < 4*HALF + 4; k++) begin
      @(negedge clk);
      if (sclk_out && !prev) rises++;
      prev = sclk_out;
    end
    check("R11 no burst in external mode", 12'(rises), 12'd0);
    cs_n = 1'b1; rd_conv = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule